// File: doc/BRIEF.md
# Multicart ROM Bank Mapper

This block sits on the cartridge side of an 8-bit CPU that has a 16-bit address bus. CPU reads in the lower 32 KiB pass through to a larger external ROM. CPU writes into the same range set three small control registers: a 5-bit low bank field, a 2-bit high bank field and a mode flag. Each ROM byte address is formed as a 7-bit bank number times 16 KiB plus the 14-bit offset inside the bank. Accesses are decoded on CPU address bits [15:13] only.

In plain mode the lower 16 KiB window is fixed to bank 0. The upper window follows the combined bank number, and a zero value in the low field is bumped up by one. In multicart mode the high field picks one of four sub-cartridges of 16 banks each. Only four low-field bits select inside that sub-cartridge, and the lower window moves to the first bank of the selected sub-cartridge. Register updates happen on the clock edge. The ROM address is combinational from the registered state and the current CPU address.

Top module: `multicart_rom_mapper`

## Requirements
- R1: After reset the mode flag is plain, the high field is 0 and the low field is 1, so the lower-window debug bank is 0 and the upper-window debug bank is 1.
- R2: A write with CPU address bits [15:13] = 3'b001 stores write-data bits [4:0] in the low bank field.
- R3: A write with CPU address bits [15:13] = 3'b010 stores write-data bits [1:0] in the high bank field.
- R4: A write with CPU address bits [15:13] = 3'b011 stores write-data bit 0 as the mode flag, where 0 is plain and 1 is multicart.
- R5: Writes with address bits [15:13] = 3'b000, and writes at or above 0x8000, change neither bank field nor the mode.
- R6: In plain mode the upper bank equals {high, low}, except that it equals {high, 5'd1} when the low field is 0. This covers the values 0x00, 0x20, 0x40 and 0x60.
- R7: In plain mode the lower bank is 0, so a read from 0x0000–0x3FFF drives the ROM address with the CPU address.
- R8: In multicart mode the lower bank is {0, high, 4'b0000} and the upper bank is {0, high, low[3:0]}, with no zero-bank bump.
- R9: The ROM address is {bank, cpu_addr[13:0]}, AND-ed with a mask that keeps the low ROM_USED_W bits. The lower bank is used when address bit 14 is 0 and the upper bank when it is 1.
- R10: Read data equals the ROM data for a read strobe below 0x8000. It is 0xFF at or above 0x8000, and 0xFF when no read is strobed.
- R11: A register write takes effect on the clock edge while the write strobe is high. The mapping in the following cycle already uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wr_i | input | 1 | Write strobe |
| rom_addr_o | output | 21 | External ROM byte address |
| rom_data_i | input | 8 | External ROM data |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |
| dbg_lo_bank_o | output | 7 | Bank currently mapped in the lower window |
| dbg_hi_bank_o | output | 7 | Bank currently mapped in the upper window |

## Verification
The bench drives the low field to zero with each of the four high-field values in plain mode. A mapper that skips the bump would select banks 0x00, 0x20, 0x40 or 0x60 in the upper window and alias the fixed window. Multicart settings with bit 4 of the low field set expose a mapper that keeps five low bits or forgets to move the lower window, because such a mapper reads the wrong sub-cartridge. Writes to the first region and above 0x8000 are followed by mapping checks, which catch a decoder that looks at too few address bits. Reads above 0x8000 must return 0xFF, not ROM data.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int CPU_AW   = 16;
  localparam int CPU_DW   = 8;
  localparam int LO_W     = 5;
  localparam int HI_W     = 2;
  localparam int SUB_LO_W = 4;
  localparam int BANK_W   = LO_W + HI_W;
  localparam int OFS_W    = 14;
  localparam int ROM_AW   = BANK_W + OFS_W;
  localparam int RGN_W    = 3;

  typedef enum logic [RGN_W-1:0] {
    RGN_FIX   = 3'd0,
    RGN_LO    = 3'd1,
    RGN_HI    = 3'd2,
    RGN_MODE  = 3'd3
  } region_e;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic            multi;
  } bank_state_t;
endpackage

// File: rtl/mcm_regs.sv
module mcm_regs
  import mcm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RGN_W-1:0]  rgn_i,
  input  logic [CPU_DW-1:0] wdata_i,
  output bank_state_t       state_o
);
  bank_state_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q.hi    <= '0;
      state_q.lo    <= LO_W'(1);
      state_q.multi <= 1'b0;
    end else if (wr_i) begin
      unique case (rgn_i)
        RGN_LO:   state_q.lo    <= wdata_i[LO_W-1:0];
        RGN_HI:   state_q.hi    <= wdata_i[HI_W-1:0];
        RGN_MODE: state_q.multi <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mcm_bank_map.sv
module mcm_bank_map
  import mcm_pkg::*;
(
  input  bank_state_t       state_i,
  output logic [BANK_W-1:0] lower_bank_o,
  output logic [BANK_W-1:0] upper_bank_o
);
  logic [BANK_W-1:0] plain_upper;
  logic [BANK_W-1:0] multi_lower;
  logic [BANK_W-1:0] multi_upper;

  // zero low field never maps the switchable window onto a fixed-window bank
  always_comb begin
    plain_upper = {state_i.hi, state_i.lo};
    if (state_i.lo == '0) plain_upper = {state_i.hi, LO_W'(1)};
  end

  // high field moves down one bit position to pick a 16-bank sub-cartridge
  assign multi_lower = BANK_W'({state_i.hi, {SUB_LO_W{1'b0}}});
  assign multi_upper = BANK_W'({state_i.hi, state_i.lo[SUB_LO_W-1:0]});

  assign lower_bank_o = state_i.multi ? multi_lower : '0;
  assign upper_bank_o = state_i.multi ? multi_upper : plain_upper;
endmodule

// File: rtl/mcm_rom_port.sv
module mcm_rom_port
  import mcm_pkg::*;
#(
  parameter int ROM_USED_W = ROM_AW
) (
  input  logic [CPU_AW-1:0] addr_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] lower_bank_i,
  input  logic [BANK_W-1:0] upper_bank_i,
  input  logic [CPU_DW-1:0] rom_data_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [CPU_DW-1:0] rdata_o
);
  logic [ROM_AW-1:0] full_addr;
  logic              in_rom;

  assign in_rom    = ~addr_i[CPU_AW-1];
  assign full_addr = {addr_i[OFS_W] ? upper_bank_i : lower_bank_i, addr_i[OFS_W-1:0]};

  generate
    if (ROM_USED_W >= ROM_AW) begin : g_full
      assign rom_addr_o = full_addr;
    end else begin : g_masked
      assign rom_addr_o = {{(ROM_AW-ROM_USED_W){1'b0}}, full_addr[ROM_USED_W-1:0]};
    end
  endgenerate

  assign rdata_o = (rd_i && in_rom) ? rom_data_i : {CPU_DW{1'b1}};
endmodule

// File: rtl/multicart_rom_mapper.sv
module multicart_rom_mapper
  import mcm_pkg::*;
#(
  parameter int ROM_USED_W = ROM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [CPU_DW-1:0] rom_data_i,
  output logic [CPU_DW-1:0] cpu_rdata_o,
  output logic [BANK_W-1:0] dbg_lo_bank_o,
  output logic [BANK_W-1:0] dbg_hi_bank_o
);
  bank_state_t       state;
  logic [BANK_W-1:0] lower_bank;
  logic [BANK_W-1:0] upper_bank;
  logic              mode_q;

  mcm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cpu_wr_i),
    .rgn_i   (cpu_addr_i[CPU_AW-1 -: RGN_W]),
    .wdata_i (cpu_wdata_i),
    .state_o (state)
  );

  mcm_bank_map u_map (
    .state_i      (state),
    .lower_bank_o (lower_bank),
    .upper_bank_o (upper_bank)
  );

  mcm_rom_port #(.ROM_USED_W(ROM_USED_W)) u_port (
    .addr_i       (cpu_addr_i),
    .rd_i         (cpu_rd_i),
    .lower_bank_i (lower_bank),
    .upper_bank_i (upper_bank),
    .rom_data_i   (rom_data_i),
    .rom_addr_o   (rom_addr_o),
    .rdata_o      (cpu_rdata_o)
  );

  assign mode_q        = state.multi;
  assign dbg_lo_bank_o = lower_bank;
  assign dbg_hi_bank_o = upper_bank;
endmodule

// File: rtl/mcm_checker.sv
module mcm_checker
  import mcm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CPU_AW-1:0] cpu_addr_i,
  input logic [CPU_DW-1:0] cpu_wdata_i,
  input logic              cpu_rd_i,
  input logic              cpu_wr_i,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [CPU_DW-1:0] cpu_rdata_o,
  input logic [BANK_W-1:0] dbg_lo_bank_o,
  input logic [BANK_W-1:0] dbg_hi_bank_o,
  input logic              mode_q
);
  logic unused_chk;
  assign unused_chk = ^{cpu_rd_i, cpu_wdata_i[CPU_DW-1:1]};

  a_r5_fix_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[CPU_AW-1 -: RGN_W] == 3'd0)
    |=> ($stable(dbg_lo_bank_o) && $stable(dbg_hi_bank_o) && $stable(mode_q)));

  a_r4_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i[CPU_AW-1 -: RGN_W] == 3'd3)
    |=> (mode_q == $past(cpu_wdata_i[0])));

  a_r6_plain_no_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (dbg_hi_bank_o[LO_W-1:0] != '0));

  a_r7_plain_lower_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (dbg_lo_bank_o == '0));

  a_r8_multi_sub_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> (dbg_lo_bank_o[SUB_LO_W-1:0] == '0 &&
                dbg_hi_bank_o[BANK_W-1:SUB_LO_W] == dbg_lo_bank_o[BANK_W-1:SUB_LO_W]));

  a_r9_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[OFS_W-1:0] == cpu_addr_i[OFS_W-1:0]);

  a_r10_high_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[CPU_AW-1] |-> (cpu_rdata_o == {CPU_DW{1'b1}}));
endmodule

bind multicart_rom_mapper mcm_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_addr_i    (cpu_addr_i),
  .cpu_wdata_i   (cpu_wdata_i),
  .cpu_rd_i      (cpu_rd_i),
  .cpu_wr_i      (cpu_wr_i),
  .rom_addr_o    (rom_addr_o),
  .cpu_rdata_o   (cpu_rdata_o),
  .dbg_lo_bank_o (dbg_lo_bank_o),
  .dbg_hi_bank_o (dbg_hi_bank_o),
  .mode_q        (mode_q)
);

// File: tb/multicart_rom_mapper_tb_top.sv
module multicart_rom_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic        cpu_rd_i = 1'b0;
  logic        cpu_wr_i = 1'b0;
  logic [20:0] rom_addr_o;
  logic [7:0]  rom_data_i;
  logic [7:0]  cpu_rdata_o;
  logic [6:0]  dbg_lo_bank_o;
  logic [6:0]  dbg_hi_bank_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_lo;
  logic [1:0] m_hi;
  logic       m_multi;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] rom_byte(logic [20:0] a);
    return a[7:0] ^ {a[20:14], 1'b1};
  endfunction

  assign rom_data_i = rom_byte(rom_addr_o);

  multicart_rom_mapper dut_i (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_wdata_i, .cpu_rd_i, .cpu_wr_i,
    .rom_addr_o, .rom_data_i, .cpu_rdata_o, .dbg_lo_bank_o, .dbg_hi_bank_o
  );

  function automatic logic [6:0] exp_upper();
    if (m_multi) return {1'b0, m_hi, m_lo[3:0]};
    if (m_lo == 5'd0) return {m_hi, 5'd1};
    return {m_hi, m_lo};
  endfunction

  function automatic logic [6:0] exp_lower();
    return m_multi ? {1'b0, m_hi, 4'd0} : 7'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_wr_i = 1'b1; cpu_rd_i = 1'b0;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    case (a[15:13])
      3'd1: m_lo = d[4:0];
      3'd2: m_hi = d[1:0];
      3'd3: m_multi = d[0];
      default: ;
    endcase
  endtask

  task automatic check_banks(string req);
    chk(req, 32'(dbg_lo_bank_o), 32'(exp_lower()));
    chk(req, 32'(dbg_hi_bank_o), 32'(exp_upper()));
  endtask

  task automatic rd(logic [15:0] a, string req);
    logic [20:0] ea;
    @(negedge clk_i);
    cpu_addr_i = a; cpu_rd_i = 1'b1;
    #5;
    ea = {a[14] ? exp_upper() : exp_lower(), a[13:0]};
    if (!a[15]) begin
      chk(req, 32'(rom_addr_o), 32'(ea));
      chk(req, 32'(cpu_rdata_o), 32'(rom_byte(ea)));
    end else begin
      chk(req, 32'(cpu_rdata_o), 32'hFF);
    end
    cpu_rd_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    m_lo = 5'd1; m_hi = 2'd0; m_multi = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset mapping
    check_banks("R1");
    rd(16'h0123, "R7");
    rd(16'h4567, "R9");
    // R10 idle read data
    @(negedge clk_i); cpu_addr_i = 16'h1000; cpu_rd_i = 1'b0; #5;
    chk("R10", 32'(cpu_rdata_o), 32'hFF);
    // R6 zero-low bump for every high value
    for (int h = 0; h < 4; h++) begin
      wr(16'h4000, 8'(h));
      wr(16'h2000, 8'hE0);
      check_banks("R6");
      rd(16'h7FFF, "R6");
    end
    // R2 R3 R11 field widths and next-cycle effect
    wr(16'h3FFF, 8'hFF); check_banks("R2");
    wr(16'h5ABC, 8'hFE); check_banks("R3");
    rd(16'h4001, "R11");
    // R8 multicart with low bit 4 set
    wr(16'h6000, 8'h03);
    wr(16'h4000, 8'h02); wr(16'h2000, 8'h15);
    check_banks("R8");
    chk("R8", 32'(dbg_lo_bank_o), 32'h20);
    chk("R8", 32'(dbg_hi_bank_o), 32'h25);
    rd(16'h0010, "R8");
    rd(16'h4010, "R8");
    wr(16'h2000, 8'h00); check_banks("R8");
    chk("R4", 32'(dbg_hi_bank_o), 32'h20);
    // R5 ignored writes
    wr(16'h1F00, 8'hFF); check_banks("R5");
    wr(16'hA000, 8'h07); check_banks("R5");
    wr(16'hC000, 8'h00); check_banks("R5");
    wr(16'hE000, 8'h1F); check_banks("R5");
    rd(16'h8000, "R10");
    rd(16'hFFFF, "R10");
    wr(16'h7FFF, 8'hFE); check_banks("R4");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom_range(0, 2) != 0) begin
        wr(a, 8'($urandom));
        check_banks("R11");
      end
      rd(16'($urandom), "R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule